// File: doc/BRIEF.md
# Freezable Counter with Deferred Increment

This block holds a 24-bit binary count that advances by one on each increment request from a slow timebase and wraps from FFFFFFh back to 000000h. While a host access is under way the surrounding logic raises a freeze flag, and the count then stays put so that any read in progress sees one stable value. An increment that arrives during the freeze is not thrown away. It is parked in a single pending slot and carried out once the freeze lifts. A second increment within the same freeze finds the slot already occupied and is lost.

The count can also be written one byte at a time. A strobe carries a byte index and a data byte, and only the eight bits named by the index change. A host that stops after the top byte has therefore altered bits 23:16 and nothing else. A write takes priority over an increment in the same cycle, and the increment is kept for later. Writes are accepted whether or not the freeze flag is high, because the writes normally arrive inside a host access. A one-cycle step pulse comes out in the same cycle that the incremented value first appears, so logic that wakes on the pulse reads the new count at once.

Top module: `frz_counter`

## Requirements
- R1: After reset the count is 000000h, the step pulse is low and no increment is pending.
- R2: With freeze low, no byte write and an increment request, the count rises by exactly one at the next clock edge, and the step pulse is high in the same cycle the new value is visible.
- R3: An increment from FFFFFFh gives 000000h.
- R4: While freeze is high and no byte write is accepted, the count keeps its value and the step pulse stays low.
- R5: An increment requested while frozen is applied at the clock edge that ends the first cycle in which freeze is low and no byte write is accepted.
- R6: Only one increment is held per freeze. Further requests during the same freeze are dropped, so releasing the freeze gives exactly one step.
- R7: Byte index 0 writes bits 23:16, index 1 writes bits 15:8 and index 2 writes bits 7:0. All other bits keep their value. Index 3 is ignored and leaves the count unchanged.
- R8: In a cycle with an accepted byte write the count takes the written byte and does not increment. A request or pending increment from that cycle stays pending and is applied in the next free cycle.
- R9: When the freeze lifts in the same cycle as a fresh request arrives, both increments are honoured on two successive edges.
- R10: Byte writes are accepted while freeze is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_req | input | 1 | One-cycle increment request from the timebase |
| freeze | input | 1 | High while a host access is in progress |
| load_stb | input | 1 | Byte write strobe |
| load_idx | input | 2 | Byte index: 0 = bits 23:16, 1 = bits 15:8, 2 = bits 7:0, 3 = ignored |
| load_byte | input | 8 | Byte to write |
| count | output | 24 | Current count value |
| step | output | 1 | High in the cycle a freshly incremented count is first visible |

## Verification
The bench uses the default 24-bit count made of three 8-bit bytes. At that width the wrap from FFFFFFh is reached by writing FFh, FFh and FEh through the byte port and then stepping twice. Index 3 is also available as an unused code, so the ignored-index case can be driven. A long mixed run of random requests, freezes and writes of all four indices is compared cycle by cycle against a behavioural model. The run includes freezes that span several requests and writes that coincide with a pending increment.

// File: rtl/frz_counter_pkg.sv
package frz_counter_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_STEP = 2'd1,
        ACT_HOLD = 2'd2
    } sched_act_e;

endpackage

// File: rtl/frz_byte_merge.sv
module frz_byte_merge #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    localparam int NUM_BYTES = CNT_W / BYTE_W,
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES + 1) : 1
) (
    input  logic [CNT_W-1:0]  cur_val,
    input  logic              load_stb,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [CNT_W-1:0]  merged_val,
    output logic              load_hit
);

    logic [NUM_BYTES-1:0] sel;

    generate
        for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
            // index 0 addresses the most significant byte
            localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(NUM_BYTES - 1 - g);
            assign sel[g] = load_stb && (load_idx == LANE_IDX);
            assign merged_val[g*BYTE_W +: BYTE_W] =
                sel[g] ? load_byte : cur_val[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    assign load_hit = |sel;

endmodule

// File: rtl/frz_step_sched.sv
module frz_step_sched
    import frz_counter_pkg::*;
(
    input  logic       inc_req,
    input  logic       pending_q,
    input  logic       freeze,
    input  logic       load_hit,
    output sched_act_e act,
    output logic       pending_d
);

    logic [1:0] demand;
    logic       blocked;

    always_comb begin
        demand  = {1'b0, pending_q} + {1'b0, inc_req};
        blocked = freeze || load_hit;
        act       = ACT_IDLE;
        pending_d = 1'b0;
        if (demand != 2'd0) begin
            if (blocked) begin
                // one slot only: a second request is lost
                act       = ACT_HOLD;
                pending_d = 1'b1;
            end else begin
                act       = ACT_STEP;
                pending_d = (demand == 2'd2);
            end
        end
    end

endmodule

// File: rtl/frz_counter.sv
module frz_counter
    import frz_counter_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    localparam int NUM_BYTES = CNT_W / BYTE_W,
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_req,
    input  logic              freeze,
    input  logic              load_stb,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [BYTE_W-1:0] load_byte,
    output logic [CNT_W-1:0]  count,
    output logic              step
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             pending;
        logic             step;
    } ctr_state_t;

    ctr_state_t st_q, st_d;

    logic [CNT_W-1:0] merged_val;
    logic             load_hit;
    sched_act_e       act;
    logic             pending_nx;

    frz_byte_merge #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_merge (
        .cur_val   (st_q.count),
        .load_stb  (load_stb),
        .load_idx  (load_idx),
        .load_byte (load_byte),
        .merged_val(merged_val),
        .load_hit  (load_hit)
    );

    frz_step_sched u_sched (
        .inc_req  (inc_req),
        .pending_q(st_q.pending),
        .freeze   (freeze),
        .load_hit (load_hit),
        .act      (act),
        .pending_d(pending_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.step    = 1'b0;
        st_d.pending = pending_nx;
        if (load_hit) begin
            st_d.count = merged_val;
        end else if (act == ACT_STEP) begin
            st_d.count = st_q.count + CNT_W'(1);
            st_d.step  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign step  = st_q.step;

    assert_hold_when_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load_hit) |=> (count == $past(count)));

    assert_step_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (count == CNT_W'($past(count) + CNT_W'(1))));

    assert_no_step_when_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze || load_hit) |=> !step);

    assert_pending_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && !freeze && !load_hit) |=> step);

    assert_load_takes_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |=> (count == $past(merged_val)));

endmodule

// File: tb/frz_counter_test.sv
module frz_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_req = 1'b0;
    logic        freeze = 1'b0;
    logic        load_stb = 1'b0;
    logic [1:0]  load_idx = 2'd0;
    logic [7:0]  load_byte = 8'd0;
    logic [23:0] count;
    logic        step;

    int n_checks = 0;
    int n_fail = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [23:0] m_cnt = 24'd0;
    bit          m_pend = 1'b0;
    bit          m_step = 1'b0;

    always #5 clk = ~clk;

    frz_counter uut (
        .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .freeze(freeze),
        .load_stb(load_stb), .load_idx(load_idx), .load_byte(load_byte),
        .count(count), .step(step)
    );

    // behavioural reference
    always @(posedge clk) begin
        int want;
        if (!rst_n) begin
            m_cnt = 24'd0; m_pend = 1'b0; m_step = 1'b0;
        end else begin
            want = int'(m_pend) + int'(inc_req);
            m_step = 1'b0;
            if (load_stb && load_idx != 2'd3) begin
                case (load_idx)
                    2'd0: m_cnt[23:16] = load_byte;
                    2'd1: m_cnt[15:8]  = load_byte;
                    default: m_cnt[7:0] = load_byte;
                endcase
                m_pend = (want > 0);
            end else if (freeze) begin
                m_pend = (want > 0);
            end else if (want > 0) begin
                m_cnt = m_cnt + 24'd1;
                m_step = 1'b1;
                m_pend = (want == 2);
            end
        end
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, count, m_cnt);
            chk(cur_req, {23'd0, step}, {23'd0, m_step});
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc_cnt);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic cyc(input bit inc, input bit frz, input bit ld,
                       input logic [1:0] idx, input logic [7:0] b);
        inc_req = inc; freeze = frz; load_stb = ld; load_idx = idx; load_byte = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, 8'd0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1", count, 24'd0);
        chk("R1", {23'd0, step}, 24'd0);

        cur_req = "R2";
        cyc(1, 0, 0, 2'd0, 8'd0);
        chk("R2", count, 24'h000001); chk("R2", {23'd0, step}, 24'd1);
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R2", {23'd0, step}, 24'd0);
        cyc(1, 0, 0, 2'd0, 8'd0);
        chk("R2", count, 24'h000002);

        cur_req = "R3";
        cyc(0, 0, 1, 2'd0, 8'hFF);
        cyc(0, 0, 1, 2'd1, 8'hFF);
        cyc(0, 0, 1, 2'd2, 8'hFE);
        chk("R7", count, 24'hFFFFFE);
        cyc(1, 0, 0, 2'd0, 8'd0);
        chk("R3", count, 24'hFFFFFF);
        cyc(1, 0, 0, 2'd0, 8'd0);
        chk("R3", count, 24'h000000); chk("R3", {23'd0, step}, 24'd1);

        cur_req = "R4";
        cyc(1, 1, 0, 2'd0, 8'd0);
        chk("R4", count, 24'h000000); chk("R4", {23'd0, step}, 24'd0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 2'd0, 8'd0);
        chk("R4", count, 24'h000000);
        cur_req = "R5";
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R5", count, 24'h000001); chk("R5", {23'd0, step}, 24'd1);

        cur_req = "R6";
        cyc(1, 1, 0, 2'd0, 8'd0);
        cyc(0, 1, 0, 2'd0, 8'd0);
        cyc(1, 1, 0, 2'd0, 8'd0);
        cyc(0, 1, 0, 2'd0, 8'd0);
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R6", count, 24'h000002);
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R6", count, 24'h000002); chk("R6", {23'd0, step}, 24'd0);

        cur_req = "R7";
        cyc(0, 0, 1, 2'd0, 8'h12);
        chk("R7", count, 24'h120002);
        cyc(0, 0, 1, 2'd3, 8'h55);
        chk("R7", count, 24'h120002);

        cur_req = "R8";
        cyc(1, 0, 1, 2'd2, 8'h10);
        chk("R8", count, 24'h120010); chk("R8", {23'd0, step}, 24'd0);
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R8", count, 24'h120011); chk("R8", {23'd0, step}, 24'd1);

        cur_req = "R9";
        cyc(1, 1, 0, 2'd0, 8'd0);
        cyc(1, 0, 0, 2'd0, 8'd0);
        chk("R9", count, 24'h120012);
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R9", count, 24'h120013); chk("R9", {23'd0, step}, 24'd1);

        cur_req = "R10";
        cyc(0, 1, 1, 2'd1, 8'hAB);
        chk("R10", count, 24'h12AB13);
        cyc(0, 0, 0, 2'd0, 8'd0);
        chk("R10", count, 24'h12AB13); chk("R10", {23'd0, step}, 24'd0);

        cur_req = "R2/R4/R6/R7 mixed";
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0,
                2'($urandom % 4), 8'($urandom));
        end
        idle(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule